// File: doc/BRIEF.md
# SCSI Controller Command Dispatcher

This block sits between a host register bus and the bus sequencer of a SCSI protocol controller. The host writes one-byte commands into a command register. The dispatcher checks each command against the live connection state and bus phase that the sequencer reports. A command that is allowed produces a one-cycle start strobe, together with the operation code and a DMA request flag. A command that is not allowed is refused and raises an illegal-command cause. The dispatcher also holds an interrupt-cause register, a configuration register and a status register. The low bits of the status register mirror the current bus phase.

Each register is one byte wide. Registers are spaced a fixed power-of-two stride apart in the byte address space, so the register index is the address with its low stride bits dropped. Bus signalling, arbitration, selection timing and the DMA engine are outside this block. The sequencer's connection flag and phase code arrive as plain inputs. The operations leave as strobes.

Top module: `scsi_cmd_dispatch`

## Requirements
- R1: The register index is the byte address shifted right by STRIDE_LOG2 (default 2). Index 3 holds the last command, index 4 is status, index 5 is the interrupt causes, and index 8 is the configuration register, which reads back what was written to it.
- R2: A write to index 3 that is allowed drives `op_start` high for exactly the next cycle. In that cycle `op_code` equals bits 6:0 of the written byte and `op_dma` equals bit 7. Bit 7 plays no part in the legality check.
- R3: Opcodes 0x00, 0x01, 0x02 and 0x03 are allowed in every connection state and phase. None of them sets a cause, except for the bus-reset case in R8.
- R4: Opcodes 0x10, 0x11, 0x12, 0x18, 0x1A and 0x1B are allowed only while `conn_i` is high.
- R5: Opcodes 0x20 to 0x2B are allowed only while `conn_i` is high and `phase_i` is 6 (message out) or 7 (message in).
- R6: Opcodes 0x40 to 0x47 are allowed only while `conn_i` is low.
- R7: A command that is not allowed, including any opcode not listed in R3 to R6, starts no operation. One cycle after the write, it sets cause bit 6.
- R8: Opcode 0x03 (bus reset) sets cause bit 7 one cycle after the write, unless configuration bit 6 is set.
- R9: A status read returns `phase_i` in bits 2:0, the pending-interrupt flag in bit 7, and zero in bits 6:3. `irq` is high exactly when any cause bit is set.
- R10: A read of index 5 returns the cause bits and clears them. `irq` is low from the following cycle.
- R11: Opcode 0x02 (chip reset) clears the causes, the configuration register and the stored command in the cycle after the write.
- R12: Writes to index 4, index 5 and unmapped indices change nothing. Reads of unmapped indices return zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| wr_en | input | 1 | Register write strobe |
| rd_en | input | 1 | Register read strobe |
| addr | input | ADDR_W | Byte address |
| wdata | input | 8 | Write data |
| rdata | output | 8 | Read data |
| conn_i | input | 1 | Connected to a target as initiator |
| phase_i | input | 3 | Current bus phase code |
| op_start | output | 1 | One-cycle operation start strobe |
| op_code | output | 7 | Operation code of the started command |
| op_dma | output | 1 | DMA requested for the started command |
| irq | output | 1 | Interrupt request |

## Verification
The bench builds the block with ADDR_W of 6, STRIDE_LOG2 of 2 and combinational read data. With these values all nine register indices are reachable, and results can be sampled in the same cycle as the read. Random opcodes are drawn from every command group and from the undefined gaps. They are issued under random connection states and phases, so every legality rule is exercised in both its allowed and its refused form. Directed cases cover bus reset with the reset report masked and unmasked, chip reset after configuration writes, and writes to the read-only indices.

// File: rtl/scsi_disp_pkg.sv
package scsi_disp_pkg;
   localparam int BYTE_W   = 8;
   localparam int OP_W     = 7;
   localparam int IDX_CMD  = 3;
   localparam int IDX_STAT = 4;
   localparam int IDX_INTR = 5;
   localparam int IDX_CFG  = 8;
   localparam int CAUSE_ILL = 6;
   localparam int CAUSE_BRS = 7;
   localparam int CFG_NOBRS = 6;

   typedef enum logic [OP_W-1:0] {
      OPC_NOP     = 7'h00,
      OPC_FLUSH   = 7'h01,
      OPC_CHIPRST = 7'h02,
      OPC_BUSRST  = 7'h03
   } opc_any_e;

   typedef enum logic [1:0] {
      CLS_ANY   = 2'd0,
      CLS_CONN  = 2'd1,
      CLS_MSG   = 2'd2,
      CLS_IDLE  = 2'd3
   } cmd_class_e;
endpackage

// File: rtl/scsi_cmd_classify.sv
module scsi_cmd_classify
   import scsi_disp_pkg::*;
(
   input  logic [OP_W-1:0] op,
   input  logic            conn,
   input  logic [2:0]      phase,
   output logic            legal,
   output logic            chip_rst,
   output logic            bus_rst
);
   cmd_class_e cls;
   logic       known;

   always_comb begin
      cls   = CLS_ANY;
      known = 1'b0;
      case (op) inside
         [7'h00:7'h03]: begin cls = CLS_ANY;  known = 1'b1; end
         7'h10, 7'h11, 7'h12, 7'h18, 7'h1A, 7'h1B:
                        begin cls = CLS_CONN; known = 1'b1; end
         [7'h20:7'h2B]: begin cls = CLS_MSG;  known = 1'b1; end
         [7'h40:7'h47]: begin cls = CLS_IDLE; known = 1'b1; end
         default:       begin cls = CLS_ANY;  known = 1'b0; end
      endcase
   end

   always_comb begin
      legal = 1'b0;
      if (known) begin
         case (cls)
            CLS_ANY:  legal = 1'b1;
            CLS_CONN: legal = conn;
            CLS_MSG:  legal = conn && (phase[2:1] == 2'b11);
            CLS_IDLE: legal = !conn;
            default:  legal = 1'b0;
         endcase
      end
   end

   assign chip_rst = (op == OPC_CHIPRST);
   assign bus_rst  = (op == OPC_BUSRST);
endmodule

// File: rtl/scsi_irq_cause.sv
module scsi_irq_cause
   import scsi_disp_pkg::*;
(
   input  logic              clk,
   input  logic              rst_n,
   input  logic              clr_all,
   input  logic              rd_clr,
   input  logic              set_ill,
   input  logic              set_brs,
   output logic [BYTE_W-1:0] cause,
   output logic              irq
);
   logic [BYTE_W-1:0] set_vec;

   always_comb begin
      set_vec = '0;
      set_vec[CAUSE_ILL] = set_ill;
      set_vec[CAUSE_BRS] = set_brs;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)       cause <= '0;
      else if (clr_all) cause <= '0;
      else if (rd_clr)  cause <= set_vec;
      else              cause <= cause | set_vec;
   end

   assign irq = |cause;
endmodule

// File: rtl/scsi_cmd_dispatch.sv
module scsi_cmd_dispatch
   import scsi_disp_pkg::*;
#(
   parameter int ADDR_W      = 6,
   parameter int STRIDE_LOG2 = 2,
   parameter bit RDATA_REG   = 1'b0
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr_en,
   input  logic              rd_en,
   input  logic [ADDR_W-1:0] addr,
   input  logic [7:0]        wdata,
   output logic [7:0]        rdata,
   input  logic              conn_i,
   input  logic [2:0]        phase_i,
   output logic              op_start,
   output logic [6:0]        op_code,
   output logic              op_dma,
   output logic              irq
);
   localparam int IDX_W = ADDR_W - STRIDE_LOG2;

   if (IDX_W < 4) begin : g_bad_addr
      $error("ADDR_W must leave at least four index bits above the stride");
   end
   if (STRIDE_LOG2 < 0) begin : g_bad_stride
      $error("STRIDE_LOG2 must not be negative");
   end

   logic [IDX_W-1:0]  idx;
   logic              wr_cmd, wr_cfg, rd_intr;
   logic              legal, is_chip, is_bus;
   logic [BYTE_W-1:0] cfg_q, cmd_q, cause;
   logic [BYTE_W-1:0] rd_mux;
   logic              start_q, dma_q;
   logic [OP_W-1:0]   code_q;

   assign idx     = addr[ADDR_W-1:STRIDE_LOG2];
   assign wr_cmd  = wr_en && (idx == IDX_W'(IDX_CMD));
   assign wr_cfg  = wr_en && (idx == IDX_W'(IDX_CFG));
   assign rd_intr = rd_en && (idx == IDX_W'(IDX_INTR));

   scsi_cmd_classify u_cls (
      .op       (wdata[OP_W-1:0]),
      .conn     (conn_i),
      .phase    (phase_i),
      .legal    (legal),
      .chip_rst (is_chip),
      .bus_rst  (is_bus)
   );

   logic do_chip;
   assign do_chip = wr_cmd && legal && is_chip;

   scsi_irq_cause u_cause (
      .clk     (clk),
      .rst_n   (rst_n),
      .clr_all (do_chip),
      .rd_clr  (rd_intr),
      .set_ill (wr_cmd && !legal),
      .set_brs (wr_cmd && legal && is_bus && !cfg_q[CFG_NOBRS]),
      .cause   (cause),
      .irq     (irq)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cfg_q <= '0;
         cmd_q <= '0;
      end else if (do_chip) begin
         cfg_q <= '0;
         cmd_q <= '0;
      end else begin
         if (wr_cfg) cfg_q <= wdata;
         if (wr_cmd) cmd_q <= wdata;
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         start_q <= 1'b0;
         code_q  <= '0;
         dma_q   <= 1'b0;
      end else begin
         start_q <= wr_cmd && legal;
         if (wr_cmd && legal) begin
            code_q <= wdata[OP_W-1:0];
            dma_q  <= wdata[BYTE_W-1];
         end
      end
   end

   assign op_start = start_q;
   assign op_code  = code_q;
   assign op_dma   = dma_q;

   always_comb begin
      rd_mux = '0;
      if (idx == IDX_W'(IDX_CMD))  rd_mux = cmd_q;
      if (idx == IDX_W'(IDX_STAT)) rd_mux = {irq, 4'b0000, phase_i};
      if (idx == IDX_W'(IDX_INTR)) rd_mux = cause;
      if (idx == IDX_W'(IDX_CFG))  rd_mux = cfg_q;
   end

   if (RDATA_REG) begin : g_rd_reg
      logic [BYTE_W-1:0] rdata_q;
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)     rdata_q <= '0;
         else if (rd_en) rdata_q <= rd_mux;
      end
      assign rdata = rdata_q;
   end else begin : g_rd_comb
      assign rdata = rd_en ? rd_mux : '0;
   end
endmodule

// File: rtl/scsi_cmd_dispatch_chk.sv
module scsi_cmd_dispatch_chk #(
   parameter int ADDR_W      = 6,
   parameter int STRIDE_LOG2 = 2,
   parameter bit RDATA_REG   = 1'b0
) (
   input logic              clk,
   input logic              rst_n,
   input logic              wr_en,
   input logic              rd_en,
   input logic [ADDR_W-1:0] addr,
   input logic [7:0]        rdata,
   input logic              conn_i,
   input logic [2:0]        phase_i,
   input logic              op_start,
   input logic [6:0]        op_code,
   input logic              irq
);
   localparam int IDX_W = ADDR_W - STRIDE_LOG2;
   logic [IDX_W-1:0] idx;
   assign idx = addr[ADDR_W-1:STRIDE_LOG2];

   assert_start_follows_write_R2: assert property (@(posedge clk) disable iff (!rst_n)
      op_start |-> $past(wr_en && idx == IDX_W'(3)));

   assert_msg_group_phase_R5: assert property (@(posedge clk) disable iff (!rst_n)
      (op_start && op_code[6:4] == 3'b010) |-> $past(conn_i && phase_i[2:1] == 2'b11));

   assert_idle_group_disconnected_R6: assert property (@(posedge clk) disable iff (!rst_n)
      (op_start && op_code[6:3] == 4'b1000) |-> !$past(conn_i));

   assert_conn_group_connected_R4: assert property (@(posedge clk) disable iff (!rst_n)
      (op_start && op_code[6:4] == 3'b001) |-> $past(conn_i));

   assert_read_clears_irq_R10: assert property (@(posedge clk) disable iff (!rst_n)
      (rd_en && !wr_en && idx == IDX_W'(5)) |=> !irq);

   assert_chip_reset_clears_R11: assert property (@(posedge clk) disable iff (!rst_n)
      (op_start && op_code == 7'h02) |-> !irq);

   if (!RDATA_REG) begin : g_stat
      assert_status_layout_R9: assert property (@(posedge clk) disable iff (!rst_n)
         (rd_en && idx == IDX_W'(4)) |->
            (rdata[2:0] == phase_i && rdata[7] == irq && rdata[6:3] == 4'b0000));
   end
endmodule

bind scsi_cmd_dispatch scsi_cmd_dispatch_chk #(
   .ADDR_W(ADDR_W), .STRIDE_LOG2(STRIDE_LOG2), .RDATA_REG(RDATA_REG)
) u_chk (
   .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .rd_en(rd_en), .addr(addr),
   .rdata(rdata), .conn_i(conn_i), .phase_i(phase_i), .op_start(op_start),
   .op_code(op_code), .irq(irq)
);

// File: tb/scsi_cmd_dispatch_bench.sv
module scsi_cmd_dispatch_bench;
   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       wr_en = 1'b0, rd_en = 1'b0;
   logic [5:0] addr = '0;
   logic [7:0] wdata = '0;
   logic [7:0] rdata;
   logic       conn_i = 1'b0;
   logic [2:0] phase_i = '0;
   logic       op_start, op_dma, irq;
   logic [6:0] op_code;

   int  n_run = 0, n_fail = 0;
   bit  done = 1'b0;
   logic [7:0] m_cause = '0, m_cfg = '0, m_cmd = '0;

   always #4 clk = ~clk;

   scsi_cmd_dispatch u_scsi_cmd_dispatch (
      .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .rd_en(rd_en), .addr(addr),
      .wdata(wdata), .rdata(rdata), .conn_i(conn_i), .phase_i(phase_i),
      .op_start(op_start), .op_code(op_code), .op_dma(op_dma), .irq(irq)
   );

   function automatic bit ref_legal(input logic [6:0] op, input logic c, input logic [2:0] ph);
      if (op <= 7'h03) return 1'b1;
      if (op == 7'h10 || op == 7'h11 || op == 7'h12 || op == 7'h18 || op == 7'h1A || op == 7'h1B)
         return c;
      if (op >= 7'h20 && op <= 7'h2B) return c && (ph == 3'd6 || ph == 3'd7);
      if (op >= 7'h40 && op <= 7'h47) return !c;
      return 1'b0;
   endfunction

   task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
      n_run++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s actual=%h expected=%h", req, act, exp);
      end
   endtask

   // all tasks start and end just after a falling edge
   task automatic wr(input int index, input logic [7:0] d);
      wr_en = 1'b1; addr = 6'(index << 2); wdata = d;
      @(negedge clk);
      wr_en = 1'b0;
   endtask

   task automatic rd(input int index, output logic [7:0] d);
      rd_en = 1'b1; addr = 6'(index << 2);
      #1 d = rdata;
      @(negedge clk);
      rd_en = 1'b0;
   endtask

   // issue a command, check strobe, causes and irq against the model
   task automatic cmd(input logic [7:0] d, input string req);
      logic ok;
      logic [6:0] op;
      op = d[6:0];
      ok = ref_legal(op, conn_i, phase_i);
      wr(3, d);
      if (ok && op == 7'h02) begin m_cause = '0; m_cfg = '0; m_cmd = '0; end
      else m_cmd = d;
      if (!ok) m_cause[6] = 1'b1;
      if (ok && op == 7'h03 && !m_cfg[6]) m_cause[7] = 1'b1;
      check({req, " start"}, {7'd0, op_start}, {7'd0, ok});
      if (ok) begin
         check({req, " R2 code"}, {1'b0, op_code}, {1'b0, op});
         check({req, " R2 dma"}, {7'd0, op_dma}, {7'd0, d[7]});
      end
      check({req, " R9 irq"}, {7'd0, irq}, {7'd0, |m_cause});
   endtask

   task automatic drain(input string req);
      logic [7:0] v;
      rd(5, v);
      check({req, " R10 causes"}, v, m_cause);
      m_cause = '0;
      check({req, " R10 irq low"}, {7'd0, irq}, 8'd0);
   endtask

   initial begin
      logic [7:0] v;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);

      check("R9 reset irq", {7'd0, irq}, 8'd0);
      check("R2 reset start", {7'd0, op_start}, 8'd0);
      rd(5, v); check("R10 reset causes", v, 8'd0);

      // R1 configuration readback and index mapping
      wr(8, 8'h5A); m_cfg = 8'h5A;
      rd(8, v); check("R1 cfg readback", v, 8'h5A);
      wr(8, 8'h00); m_cfg = 8'h00;

      // R9 status layout across phases
      for (int p = 0; p < 8; p++) begin
         phase_i = 3'(p);
         rd(4, v); check("R9 status phase", v, {5'd0, 3'(p)});
      end

      // R7 undefined opcode, then status bit 7
      conn_i = 1'b0; phase_i = 3'd0;
      cmd(8'h05, "R7 undefined");
      phase_i = 3'd3;
      rd(4, v); check("R9 status pending", v, 8'h83);
      drain("R7");

      // R8 bus reset reported and masked
      cmd(8'h03, "R8 bus reset");
      drain("R8");
      wr(8, 8'h40); m_cfg = 8'h40;
      cmd(8'h83, "R8 masked");
      check("R8 masked irq", {7'd0, irq}, 8'd0);

      // R11 chip reset clears cfg, command and causes
      cmd(8'h44, "R6 connected illegal setup");
      conn_i = 1'b1;
      cmd(8'h44, "R6 connected");
      check("R7 pending before reset", {7'd0, irq}, 8'd1);
      cmd(8'h02, "R11 chip reset");
      check("R11 irq cleared", {7'd0, irq}, 8'd0);
      rd(8, v); check("R11 cfg cleared", v, 8'h00);
      rd(3, v); check("R11 cmd cleared", v, 8'h00);

      // R12 writes to read-only and unmapped indices
      wr(5, 8'hFF); wr(4, 8'hFF); wr(12, 8'hFF);
      check("R12 irq unchanged", {7'd0, irq}, 8'd0);
      rd(5, v); check("R12 causes unchanged", v, 8'h00);
      rd(12, v); check("R12 unmapped read", v, 8'h00);
      rd(8, v); check("R12 cfg unchanged", v, 8'h00);

      // R5 boundaries
      conn_i = 1'b1; phase_i = 3'd6;
      cmd(8'h2B, "R5 top msg-out");
      phase_i = 3'd7;
      cmd(8'hA0, "R5 dma msg-in");
      phase_i = 3'd2;
      cmd(8'h20, "R5 wrong phase");
      cmd(8'h2C, "R7 past range");
      drain("R5");

      // R3 R4 R5 R6 R7 random mix with fixed seed
      void'($urandom(32'd1234));
      for (int i = 0; i < 400; i++) begin
         logic [7:0] d;
         int sel;
         sel = int'($urandom % 6);
         case (sel)
            0: d = 8'($urandom % 4);
            1: begin
               logic [6:0] lst [6] = '{7'h10, 7'h11, 7'h12, 7'h18, 7'h1A, 7'h1B};
               d = {1'b0, lst[$urandom % 6]};
            end
            2: d = 8'(8'h20 + ($urandom % 12));
            3: d = 8'(8'h40 + ($urandom % 8));
            default: d = {1'b0, 7'($urandom)};
         endcase
         d[7] = 1'($urandom);
         conn_i  = 1'($urandom);
         phase_i = 3'($urandom);
         if ($urandom % 8 == 0) begin
            logic [7:0] c;
            c = 8'($urandom);
            wr(8, c); m_cfg = c;
         end
         cmd(d, "R3 R4 R5 R6 R7 random");
         if ($urandom % 3 == 0) drain("random");
      end
      drain("final");
      done = 1'b1;
      $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
   end

   initial begin
      repeat (100000) @(posedge clk);
      if (!done) begin
         n_run++; n_fail++;
         $display("FAIL R2 watchdog actual=hung expected=complete");
         $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
         $finish;
      end
   end
endmodule